// File: doc/BRIEF.md
# Page-Mode Parallel Memory Controller

This block is a clocked host-side controller for an asynchronous bytewide nonvolatile memory. On the memory side it drives a 17-bit address, split data-out and data-in buses with an output-drive flag, an active-low and an active-high chip enable, and active-low write and output enables. On the user side it takes one byte read or write at a time over a request/acknowledge port. The requester holds the request until a one-cycle acknowledge comes back. For reads, that acknowledge carries the read byte.

The address splits into a row (the upper fourteen bits) and a column within the row (the lower three bits). When a request hits the row that is already open, the chip stays selected and only the column bits move, which gives a short page-mode access. When a request misses, the controller deselects the chip first, waits out the precharge gap, and then reselects it with the full new address. After a set number of idle cycles with the row open, the chip is deselected and goes to standby. Every timing figure is a whole number of clock cycles, set by a parameter.

Top module: `page_mem_ctrl`

## Requirements
- R1: While reset is held, the outputs are as follows: chip deselected (low-active enable at 1 and high-active enable at 0), write enable at 1, output enable at 1, data bus not driven, acknowledge at 0.
- R2: The row is address bits [16:3] and the column is bits [2:0]. A request to the open row keeps the chip selected and only changes the address. A read of this kind is captured PAGE_ACC cycles after the address changes, so its acknowledge is seen PAGE_ACC+1 cycles after the request is raised.
- R3: A read that opens a row selects the chip with the full address and output enable low in the same cycle. The byte is captured CE_ACC cycles later.
- R4: The row bits never change while the chip is selected. Between a deselect and the next select, the chip stays deselected for at least PC_CYC cycles.
- R5: A request that is pending while a precharge runs is accepted at the clock on which the precharge ends. The deselected gap is then exactly PC_CYC cycles. A row-miss read therefore acknowledges after PC_CYC+CE_ACC+1 cycles.
- R6: Each write byte gets its own write pulse, which falls ASP_CYC cycles after the address and data are placed. The pulse lasts WP_CYC cycles on an open row. On a freshly opened row it lasts until at least CW_CYC cycles after select. Address and data stay stable through the pulse.
- R7: Output enable stays high whenever write enable is low. The controller drives the data bus only while output enable is high. It keeps the bus driven for REC_CYC cycles after write enable rises, and a following request waits out those cycles.
- R8: With the row open and no request, the chip is deselected exactly IDLE_CYC cycles after the acknowledge cycle begins.
- R9: Each request gets exactly one acknowledge, one cycle wide, and read data is valid with it. A request still high during its own acknowledge cycle is not taken again.
- R10: A run of requests within one row causes a single chip-enable falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request held until acknowledged |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Byte address: row [16:3], column [2:0] |
| reqWdata | input | 8 | Write byte |
| reqAck | output | 1 | One-cycle acknowledge |
| rdData | output | 8 | Read byte, valid with reqAck |
| memAddr | output | 17 | Memory address |
| memCeN | output | 1 | Active-low chip enable |
| memCe2 | output | 1 | Active-high chip enable |
| memWeN | output | 1 | Active-low write enable |
| memOeN | output | 1 | Active-low output enable |
| memDqOut | output | 8 | Data to memory |
| memDqOe | output | 1 | 1 = controller drives the data bus |
| memDqIn | input | 8 | Data from memory |

## Verification
The bench's memory model returns a poison byte until both the select time and the column time have passed. A controller that captures one cycle too early therefore reads wrong data, and a miscounted page access also shows up in the latency checks. Row misses arrive while the row is still open, and the bench measures the deselected gap. A reselect that comes too soon is flagged, and so is one that waits an extra cycle after the precharge ends. Requests issued in the same cycle as the previous acknowledge would be served twice by a design without the acknowledge guard. The idle-timeout check, sampled on both sides of the deadline, catches an off-by-one in either direction.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
  typedef enum logic [2:0] {
    ST_CLOSED, ST_PRE, ST_OPEN, ST_READ, ST_WSETUP, ST_WPULSE, ST_WREC
  } ctlState_t;

  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic capture;
  } dpStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pmem_datapath.sv
module pmem_datapath
  import pmem_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rowHit
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      rdData   <= '0;
    end else begin
      if (strobe.loadAddr) memAddr  <= reqAddr;
      if (strobe.loadData) memDqOut <= reqWdata;
      if (strobe.capture)  rdData   <= memDqIn;
    end
  end

  assign rowHit = (reqAddr[ADDR_W-1:COL_W] == memAddr[ADDR_W-1:COL_W]);
endmodule

// File: rtl/pmem_control.sv
module pmem_control
  import pmem_pkg::*;
#(
  parameter int CE_ACC   = 3,
  parameter int PAGE_ACC = 2,
  parameter int PC_CYC   = 2,
  parameter int ASP_CYC  = 1,
  parameter int WP_CYC   = 1,
  parameter int CW_CYC   = 3,
  parameter int REC_CYC  = 1,
  parameter int IDLE_CYC = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      rowHit,
  output dpStrobe_t strobe,
  output logic      reqAck,
  output logic      memCeN,
  output logic      memCe2,
  output logic      memWeN,
  output logic      memOeN,
  output logic      memDqOe
);
  localparam int FRESH_PULSE = maxOf(WP_CYC, CW_CYC - ASP_CYC);
  localparam int MAX_T = maxOf(maxOf(maxOf(CE_ACC, PAGE_ACC), maxOf(PC_CYC, ASP_CYC)),
                               maxOf(FRESH_PULSE, REC_CYC));
  localparam int CNT_W  = $clog2(MAX_T + 1);
  localparam int IDLE_W = $clog2(IDLE_CYC + 1);
  localparam int GAP_W  = $clog2(PC_CYC + 1);

  localparam logic [CNT_W-1:0] CE_LAST    = CNT_W'(CE_ACC - 1);
  localparam logic [CNT_W-1:0] PAGE_LAST  = CNT_W'(PAGE_ACC - 1);
  localparam logic [CNT_W-1:0] PC_LAST    = CNT_W'(PC_CYC - 1);
  localparam logic [CNT_W-1:0] ASP_LAST   = CNT_W'(ASP_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST    = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] FRESH_LAST = CNT_W'(FRESH_PULSE - 1);
  localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(REC_CYC - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CYC - 1);
  localparam logic [GAP_W-1:0]  GAP_SAT   = GAP_W'(PC_CYC);

  ctlState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDLE_W-1:0] idleCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic              freshRow;
  logic canTake, fromClosed, startFresh, startPage, startMiss, timeout;

  always_comb begin
    canTake    = reqValid && !reqAck;
    fromClosed = (state == ST_CLOSED) || (state == ST_PRE && cnt == '0);
    startFresh = canTake && fromClosed;
    startPage  = canTake && (state == ST_OPEN) && rowHit;
    startMiss  = canTake && (state == ST_OPEN) && !rowHit;
    timeout    = (state == ST_OPEN) && !canTake && (idleCnt == IDLE_LAST);
    strobe          = '0;
    strobe.loadAddr = startFresh || startPage;
    strobe.loadData = (startFresh || startPage) && reqWrite;
    strobe.capture  = (state == ST_READ) && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_CLOSED;
      cnt      <= '0;
      idleCnt  <= '0;
      freshRow <= 1'b0;
      reqAck   <= 1'b0;
      memCeN   <= 1'b1;
      memCe2   <= 1'b0;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      memDqOe  <= 1'b0;
    end else begin
      reqAck <= 1'b0;
      if (startFresh || startPage) begin
        freshRow <= startFresh;
        if (startFresh) begin
          memCeN <= 1'b0;
          memCe2 <= 1'b1;
        end
        if (reqWrite) begin
          state   <= ST_WSETUP;
          cnt     <= ASP_LAST;
          memDqOe <= 1'b1;
        end else begin
          state  <= ST_READ;
          cnt    <= startFresh ? CE_LAST : PAGE_LAST;
          memOeN <= 1'b0;
        end
      end else if (startMiss || timeout) begin
        memCeN <= 1'b1;
        memCe2 <= 1'b0;
        state  <= ST_PRE;
        cnt    <= PC_LAST;
      end else begin
        case (state)
          ST_PRE: begin
            if (cnt == '0) state <= ST_CLOSED;
            else cnt <= cnt - 1'b1;
          end
          ST_OPEN: idleCnt <= idleCnt + 1'b1;
          ST_READ: begin
            if (cnt == '0) begin
              memOeN  <= 1'b1;
              reqAck  <= 1'b1;
              state   <= ST_OPEN;
              idleCnt <= '0;
            end else cnt <= cnt - 1'b1;
          end
          ST_WSETUP: begin
            if (cnt == '0) begin
              memWeN <= 1'b0;
              state  <= ST_WPULSE;
              cnt    <= freshRow ? FRESH_LAST : WP_LAST;
            end else cnt <= cnt - 1'b1;
          end
          ST_WPULSE: begin
            if (cnt == '0) begin
              memWeN <= 1'b1;
              reqAck <= 1'b1;
              state  <= ST_WREC;
              cnt    <= REC_LAST;
            end else cnt <= cnt - 1'b1;
          end
          ST_WREC: begin
            if (cnt == '0) begin
              memDqOe <= 1'b0;
              state   <= ST_OPEN;
              idleCnt <= '0;
            end else cnt <= cnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // Deselected-cycle counter that feeds the precharge assertion
  always_ff @(posedge clk) begin
    if (!rstN) gapCnt <= GAP_SAT;
    else if (!memCeN) gapCnt <= '0;
    else if (gapCnt != GAP_SAT) gapCnt <= gapCnt + 1'b1;
  end

  assert_precharge_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> (int'(gapCnt) >= PC_CYC));
  assert_oe_off_in_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && memDqOe));
  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);
  assert_bus_held_at_we_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDqOe);
  assert_we_needs_select_R6: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memCe2));
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);
endmodule

// File: rtl/page_mem_ctrl.sv
module page_mem_ctrl
  import pmem_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int COL_W    = 3,
  parameter int CE_ACC   = 3,
  parameter int PAGE_ACC = 2,
  parameter int PC_CYC   = 2,
  parameter int ASP_CYC  = 1,
  parameter int WP_CYC   = 1,
  parameter int CW_CYC   = 3,
  parameter int REC_CYC  = 1,
  parameter int IDLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAck,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);
  dpStrobe_t strobe;
  logic      rowHit;
  logic      chipSel;

  pmem_control #(
    .CE_ACC(CE_ACC), .PAGE_ACC(PAGE_ACC), .PC_CYC(PC_CYC), .ASP_CYC(ASP_CYC),
    .WP_CYC(WP_CYC), .CW_CYC(CW_CYC), .REC_CYC(REC_CYC), .IDLE_CYC(IDLE_CYC)
  ) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .rowHit(rowHit), .strobe(strobe), .reqAck(reqAck), .memCeN(memCeN),
    .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN), .memDqOe(memDqOe)
  );

  pmem_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memDqIn(memDqIn), .memAddr(memAddr),
    .memDqOut(memDqOut), .rdData(rdData), .rowHit(rowHit)
  );

  assign chipSel = !memCeN && memCe2;

  assert_row_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && $past(chipSel)) |-> $stable(memAddr[ADDR_W-1:COL_W]));
  assert_pulse_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memDqOut)));
endmodule

// File: tb/tb_page_mem_ctrl.sv
module tb_page_mem_ctrl;
  localparam int CE_ACC = 3, PAGE_ACC = 2, PC_CYC = 2, ASP_CYC = 1;
  localparam int WP_CYC = 1, CW_CYC = 3, REC_CYC = 1, IDLE_CYC = 8;
  localparam int FRESH_W = (WP_CYC > CW_CYC - ASP_CYC) ? WP_CYC : CW_CYC - ASP_CYC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqAck;
  logic [7:0]  rdData;
  logic [16:0] memAddr;
  logic        memCeN, memCe2, memWeN, memOeN, memDqOe;
  logic [7:0]  memDqOut;
  logic [7:0]  memDqIn = 8'hEE;

  page_mem_ctrl #(
    .CE_ACC(CE_ACC), .PAGE_ACC(PAGE_ACC), .PC_CYC(PC_CYC), .ASP_CYC(ASP_CYC),
    .WP_CYC(WP_CYC), .CW_CYC(CW_CYC), .REC_CYC(REC_CYC), .IDLE_CYC(IDLE_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memCe2(memCe2), .memWeN(memWeN),
    .memOeN(memOeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural memory model, with the pin rules checked on every clock
  byte unsigned memArr [int];
  byte unsigned expMem [int];
  int selCyc = 0, colCyc = 0, deselCyc = 1000, weLowCyc = 0, lastGap = 0, ceFalls = 0;
  logic [16:0] prevAddr = '0, weAddr = '0;
  logic [7:0]  weData = '0;
  logic prevSel = 0, prevWeLow = 0, prevAck = 0, sel;

  always @(negedge clk) begin
    if (rstN) begin
      sel = !memCeN && memCe2;
      check(!(memDqOe && !memOeN), "R7", "bus contention", memOeN, 1);
      check(memWeN || memOeN, "R7", "output enable low during write pulse", memOeN, 1);
      check(memWeN || sel, "R6", "write pulse while deselected", sel, 1);
      check(!(reqAck && prevAck), "R9", "acknowledge wider than one cycle", 2, 1);
      if (sel && !prevSel) begin
        lastGap = deselCyc;
        ceFalls++;
        check(deselCyc >= PC_CYC, "R4", "precharge gap", deselCyc, PC_CYC);
        selCyc = 1;
      end else if (sel) selCyc++;
      if (sel && prevSel)
        check(memAddr[16:3] == prevAddr[16:3], "R4", "row moved while selected",
              int'(memAddr[16:3]), int'(prevAddr[16:3]));
      deselCyc = sel ? 0 : deselCyc + 1;
      colCyc = (memAddr != prevAddr || (sel && !prevSel)) ? 1 : colCyc + 1;
      if (!memWeN && !prevWeLow) begin
        weLowCyc = 1;
        weAddr = memAddr;
        weData = memDqOut;
        check(colCyc > ASP_CYC, "R6", "address setup before write pulse", colCyc - 1, ASP_CYC);
        check(memDqOe, "R6", "data not driven in pulse", 0, 1);
      end else if (!memWeN) begin
        weLowCyc++;
        check(memAddr == weAddr && memDqOut == weData && memDqOe, "R6",
              "address or data moved in pulse", int'(memAddr), int'(weAddr));
      end else if (prevWeLow) begin
        memArr[int'(weAddr)] = weData;
        check(weLowCyc >= WP_CYC, "R6", "write pulse width", weLowCyc, WP_CYC);
        check(selCyc > CW_CYC, "R6", "select to write end", selCyc - 1, CW_CYC);
        check(memDqOe, "R7", "bus released before write enable high", 0, 1);
      end
      prevWeLow = !memWeN;
      prevSel = sel;
      prevAddr = memAddr;
      prevAck = reqAck;
      if (sel && memWeN && !memOeN && selCyc >= CE_ACC && colCyc >= PAGE_ACC &&
          memArr.exists(int'(memAddr)))
        memDqIn = memArr[int'(memAddr)];
      else
        memDqIn = 8'hEE;
    end else begin
      prevSel = 0;
      prevWeLow = 0;
      prevAck = 0;
      deselCyc = 1000;
    end
  end

  task automatic doReq(input bit wr, input logic [16:0] a, input logic [7:0] d,
                       input int gap, output logic [7:0] rd, output int lat);
    repeat (gap) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!reqAck && lat < 200);
    rd = rdData;
    reqValid = 1'b0;
  endtask

  task automatic wrByte(input logic [16:0] a, input logic [7:0] d, input int gap,
                        input int expLat, input string tag);
    logic [7:0] rd;
    int lat;
    doReq(1'b1, a, d, gap, rd, lat);
    expMem[int'(a)] = d;
    check(lat == expLat, tag, "write latency", lat, expLat);
  endtask

  task automatic rdByte(input logic [16:0] a, input int gap, input int expLat,
                        input string tag);
    logic [7:0] rd;
    int lat;
    doReq(1'b0, a, 8'h00, gap, rd, lat);
    check(lat == expLat, tag, "read latency", lat, expLat);
    check(rd == expMem[int'(a)], tag, "read data", int'(rd), int'(expMem[int'(a)]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int falls0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(memCeN == 1'b1 && memCe2 == 1'b0, "R1", "chip enables in reset", {memCeN, memCe2}, 2);
    check(memWeN == 1'b1, "R1", "write enable in reset", memWeN, 1);
    check(memOeN == 1'b1, "R1", "output enable in reset", memOeN, 1);
    check(memDqOe == 1'b0 && reqAck == 1'b0, "R1", "bus and ack in reset", {memDqOe, reqAck}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R6 R10: fresh write, then page writes in the same row
    falls0 = ceFalls;
    wrByte(17'h00100, 8'hA5, 0, ASP_CYC + FRESH_W + 1, "R6");
    for (int i = 1; i < 8; i++)
      wrByte(17'h00100 + 17'(i), 8'(8'h40 + i * 7), 3, ASP_CYC + WP_CYC + 1, "R6");
    // R2: page reads in scrambled column order
    for (int i = 0; i < 8; i++)
      rdByte(17'h00100 + 17'((i * 5 + 5) % 8), 3, PAGE_ACC + 1, "R2");
    check(ceFalls - falls0 == 1, "R10", "selects for one row run", ceFalls - falls0, 1);

    // R4 R5: row-miss write, gap exactly the precharge
    wrByte(17'h1F0A8, 8'h3C, 3, PC_CYC + ASP_CYC + FRESH_W + 1, "R5");
    check(lastGap == PC_CYC, "R5", "deselected gap on miss write", lastGap, PC_CYC);
    rdByte(17'h00103, 3, PC_CYC + CE_ACC + 1, "R4");
    check(lastGap == PC_CYC, "R5", "deselected gap on miss read", lastGap, PC_CYC);

    // R8: idle timeout after the acknowledge
    repeat (IDLE_CYC - 1) @(negedge clk);
    check(!memCeN && memCe2, "R8", "still selected before timeout", memCeN, 0);
    @(negedge clk);
    check(memCeN && !memCe2, "R8", "deselected at timeout", memCeN, 1);

    // R3: read from a closed chip
    rdByte(17'h00105, 4, CE_ACC + 1, "R3");
    check(lastGap >= PC_CYC, "R4", "gap after timeout", lastGap, PC_CYC);

    // R9 R7: back-to-back requests raised in the acknowledge cycle
    rdByte(17'h00106, 0, PAGE_ACC + 2, "R9");
    wrByte(17'h00102, 8'h77, 0, ASP_CYC + WP_CYC + 2, "R9");
    wrByte(17'h00103, 8'h88, 0, REC_CYC + ASP_CYC + WP_CYC + 1, "R7");
    rdByte(17'h00102, 0, REC_CYC + PAGE_ACC + 1, "R7");
    rdByte(17'h00103, 0, PAGE_ACC + 2, "R2");
    rdByte(17'h1F0A8, 3, PC_CYC + CE_ACC + 1, "R4");
    rdByte(17'h00100, 3, PC_CYC + CE_ACC + 1, "R3");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule